// File: doc/BRIEF.md
# Flash Save-Image Operation Engine

This block carries out program and erase requests for a flash save device whose contents live in an ordinary byte-wide memory. A requester raises a pending flag together with a page number and two selector bits. The engine latches and decodes the request, then walks the memory one byte per transfer through a valid/ready port. A page program combines a staged page buffer into the stored page with a bitwise AND, so stored bits can only fall from 1 to 0. A sector erase fills one sector with all-ones, and a chip erase fills the whole array. When the operation ends, a single-cycle done strobe tells the requester to drop its pending flag.

The memory port is a request channel. The engine holds `mem_valid` together with address, direction and write data steady until `mem_ready` is seen high at a clock edge, so the memory may stall any transfer for any number of cycles. Read data must appear on `mem_rdata` in the cycle right after the edge that accepted the read, and it is sampled only in that cycle.

Top module: `flash_op_engine`

## Requirements
- R1: After a synchronous active-high reset the engine is idle: `busy`, `done` and `mem_valid` are low.
- R2: While `req_pending` is low, the engine issues no memory transfer and stays idle.
- R3: With `req_erase`=0 the request is a page program. For each byte i, in ascending order, it reads the buffer at BUF_BASE+i, then the array at ARRAY_BASE+page*PAGE_BYTES+i, and then writes the AND of the two bytes to that array address. The total is 2*PAGE_BYTES reads and PAGE_BYTES writes.
- R4: With `req_erase`=1 and `req_whole`=0 the request is a sector erase. The page number has its low log2(SECTOR_PAGES) bits cleared, and exactly SECTOR_PAGES*PAGE_BYTES bytes from that sector start are written with 0xFF. No reads are made.
- R5: With `req_erase`=1 and `req_whole`=1 the request is a chip erase. The engine writes 0xFF to all ARRAY_PAGES*PAGE_BYTES bytes starting at ARRAY_BASE, whatever the page field holds.
- R6: `busy` rises in the cycle after a request is accepted. `done` is high for exactly one cycle, the cycle after the last write is accepted, and `busy` is high during that cycle.
- R7: A pending flag still high after `done` starts nothing until it has been seen low. It is seen low even when it drops in the same cycle as `done`.
- R8: The page and selector inputs are sampled only when a request is accepted. Changes to them while busy have no effect.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_write`, `mem_addr` and `mem_wdata` hold their values into the next cycle.
- R10: Read data is taken from `mem_rdata` only in the cycle after the read was accepted. Values in other cycles do not affect results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_pending | input | 1 | Request outstanding |
| req_erase | input | 1 | 1 = erase, 0 = page program |
| req_whole | input | 1 | With erase: 1 = whole array, 0 = one sector |
| req_page | input | PAGE_W | Target page number |
| done | output | 1 | One-cycle completion strobe |
| busy | output | 1 | Operation in progress |
| mem_valid | output | 1 | Memory transfer request |
| mem_ready | input | 1 | Memory accepts the transfer |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | DATA_W | Write byte |
| mem_rdata | input | DATA_W | Read byte, valid one cycle after read acceptance |

## Verification
The completion strobe and the re-arming of the request logic can land in the same cycle. This happens when the requester drops `req_pending` in the very cycle `done` is high and raises it again with a new request one cycle later. The bench provokes this directly: it lowers pending at the sample point where it sees `done`, then issues a sector erase. It judges the overlap by requiring `busy` one cycle after the new request, with a correct resulting memory image. The opposite case, where pending stays high across `done`, must leave the engine idle with no memory traffic for thirty cycles. Random stalls on `mem_ready`, and random bytes driven on `mem_rdata` outside the capture cycle, run through every operation.

// File: rtl/flash_op_pkg.sv
package flash_op_pkg;
  typedef enum logic [1:0] {
    OP_PROGRAM = 2'd0,
    OP_SECTOR  = 2'd1,
    OP_CHIP    = 2'd2
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_RD_BUF  = 3'd1,
    S_CAP_BUF = 3'd2,
    S_RD_ARR  = 3'd3,
    S_CAP_ARR = 3'd4,
    S_WRITE   = 3'd5,
    S_FILL    = 3'd6,
    S_DONE    = 3'd7
  } seq_e;
endpackage

// File: rtl/flash_op_decode.sv
module flash_op_decode
  import flash_op_pkg::*;
#(
  parameter int PAGE_W       = 10,
  parameter int PAGE_BYTES   = 128,
  parameter int SECTOR_PAGES = 128,
  parameter int ARRAY_PAGES  = 1024,
  parameter int CNT_W        = 18
) (
  input  logic              req_erase,
  input  logic              req_whole,
  input  logic [PAGE_W-1:0] req_page,
  output op_e               op,
  output logic [PAGE_W-1:0] start_page,
  output logic [CNT_W-1:0]  last_idx
);
  localparam int SECT_BYTES  = SECTOR_PAGES * PAGE_BYTES;
  localparam int ARRAY_BYTES = ARRAY_PAGES * PAGE_BYTES;

  logic [PAGE_W-1:0] sect_page;

  // Round the page down to its sector start when sectors hold several pages.
  generate
    if (SECTOR_PAGES > 1) begin : g_align
      assign sect_page = req_page & ~PAGE_W'(SECTOR_PAGES - 1);
    end else begin : g_noalign
      assign sect_page = req_page;
    end
  endgenerate

  always_comb begin
    op         = OP_PROGRAM;
    start_page = req_page;
    last_idx   = CNT_W'(PAGE_BYTES - 1);
    if (req_erase) begin
      if (req_whole) begin
        op         = OP_CHIP;
        start_page = '0;
        last_idx   = CNT_W'(ARRAY_BYTES - 1);
      end else begin
        op         = OP_SECTOR;
        start_page = sect_page;
        last_idx   = CNT_W'(SECT_BYTES - 1);
      end
    end
  end
endmodule

// File: rtl/flash_op_addr.sv
module flash_op_addr #(
  parameter int                ADDR_W     = 32,
  parameter int                PAGE_W     = 10,
  parameter int                PAGE_BYTES = 128,
  parameter int                CNT_W      = 18,
  parameter logic [ADDR_W-1:0] ARRAY_BASE = '0,
  parameter logic [ADDR_W-1:0] BUF_BASE   = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [PAGE_W-1:0] start_page,
  input  logic [CNT_W-1:0]  last_idx,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              is_last
);
  localparam int PAGE_SH = $clog2(PAGE_BYTES);

  logic [CNT_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst || load) idx_q <= '0;
    else if (step)   idx_q <= idx_q + 1'b1;
  end

  assign is_last  = (idx_q == last_idx);
  assign buf_addr = BUF_BASE + ADDR_W'(idx_q);
  assign arr_addr = ARRAY_BASE + (ADDR_W'(start_page) << PAGE_SH) + ADDR_W'(idx_q);
endmodule

// File: rtl/flash_op_merge.sv
module flash_op_merge #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_buf,
  input  logic              cap_arr,
  input  logic              fill,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] wdata
);
  logic [DATA_W-1:0] buf_q;
  logic [DATA_W-1:0] arr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
      arr_q <= '0;
    end else begin
      if (cap_buf) buf_q <= rdata;
      if (cap_arr) arr_q <= rdata;
    end
  end

  // Erase writes all-ones; program can only clear bits.
  assign wdata = fill ? {DATA_W{1'b1}} : (buf_q & arr_q);
endmodule

// File: rtl/flash_op_engine.sv
module flash_op_engine
  import flash_op_pkg::*;
#(
  parameter int                ADDR_W       = 32,
  parameter int                DATA_W       = 8,
  parameter int                PAGE_W       = 10,
  parameter int                PAGE_BYTES   = 128,
  parameter int                SECTOR_PAGES = 128,
  parameter int                ARRAY_PAGES  = 1024,
  parameter logic [ADDR_W-1:0] ARRAY_BASE   = '0,
  parameter logic [ADDR_W-1:0] BUF_BASE     = ADDR_W'(32'h0002_0000)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_pending,
  input  logic              req_erase,
  input  logic              req_whole,
  input  logic [PAGE_W-1:0] req_page,
  output logic              done,
  output logic              busy,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int CNT_W = $clog2(ARRAY_PAGES * PAGE_BYTES + 1);

  seq_e              state_q, state_d;
  op_e               op_q, dec_op;
  logic [PAGE_W-1:0] page_q, dec_page;
  logic [CNT_W-1:0]  last_q, dec_last;
  logic              armed_q;
  logic              accept, hs, is_last, step;
  logic [ADDR_W-1:0] buf_addr, arr_addr;

  flash_op_decode #(
    .PAGE_W(PAGE_W), .PAGE_BYTES(PAGE_BYTES), .SECTOR_PAGES(SECTOR_PAGES),
    .ARRAY_PAGES(ARRAY_PAGES), .CNT_W(CNT_W)
  ) u_decode (
    .req_erase(req_erase), .req_whole(req_whole), .req_page(req_page),
    .op(dec_op), .start_page(dec_page), .last_idx(dec_last)
  );

  flash_op_addr #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PAGE_BYTES(PAGE_BYTES), .CNT_W(CNT_W),
    .ARRAY_BASE(ARRAY_BASE), .BUF_BASE(BUF_BASE)
  ) u_addr (
    .clk(clk), .rst(rst), .load(accept), .step(step),
    .start_page(page_q), .last_idx(last_q),
    .buf_addr(buf_addr), .arr_addr(arr_addr), .is_last(is_last)
  );

  flash_op_merge #(.DATA_W(DATA_W)) u_merge (
    .clk(clk), .rst(rst),
    .cap_buf(state_q == S_CAP_BUF), .cap_arr(state_q == S_CAP_ARR),
    .fill(op_q != OP_PROGRAM), .rdata(mem_rdata), .wdata(mem_wdata)
  );

  assign accept    = (state_q == S_IDLE) && req_pending && armed_q;
  assign mem_valid = (state_q == S_RD_BUF) || (state_q == S_RD_ARR) ||
                     (state_q == S_WRITE)  || (state_q == S_FILL);
  assign mem_write = (state_q == S_WRITE) || (state_q == S_FILL);
  assign mem_addr  = (state_q == S_RD_BUF) ? buf_addr : arr_addr;
  assign hs        = mem_valid && mem_ready;
  assign step      = hs && mem_write && !is_last;
  assign done      = (state_q == S_DONE);
  assign busy      = (state_q != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      op_q    <= OP_PROGRAM;
      page_q  <= '0;
      last_q  <= '0;
      armed_q <= 1'b1;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_q    <= dec_op;
        page_q  <= dec_page;
        last_q  <= dec_last;
        armed_q <= 1'b0;
      end else if (!req_pending) begin
        armed_q <= 1'b1;
      end
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:    if (accept) state_d = (dec_op == OP_PROGRAM) ? S_RD_BUF : S_FILL;
      S_RD_BUF:  if (mem_ready) state_d = S_CAP_BUF;
      S_CAP_BUF: state_d = S_RD_ARR;
      S_RD_ARR:  if (mem_ready) state_d = S_CAP_ARR;
      S_CAP_ARR: state_d = S_WRITE;
      S_WRITE:   if (mem_ready) state_d = is_last ? S_DONE : S_RD_BUF;
      S_FILL:    if (mem_ready) state_d = is_last ? S_DONE : S_FILL;
      S_DONE:    state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end
endmodule

// File: rtl/flash_op_engine_chk.sv
module flash_op_engine_chk
  import flash_op_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic              busy,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_write,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input op_e               op_q
);
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!busy && !done && !mem_valid));

  a_r2_idle_no_traffic: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_valid);

  a_r4_erase_writes_ones: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && (op_q != OP_PROGRAM)) |-> (mem_write && (mem_wdata == {DATA_W{1'b1}})));

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_done_while_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  a_r7_idle_after_done: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);

  a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_write) && $stable(mem_addr) && $stable(mem_wdata)));
endmodule

bind flash_op_engine flash_op_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .done(done), .busy(busy), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .op_q(op_q)
);

// File: tb/flash_op_engine_tb.sv
`timescale 1ns/1ps
module flash_op_engine_tb;
  localparam int PW = 10, PB = 8, SP = 4, AP = 16, AW = 16;
  localparam int AB = PB * AP;
  localparam logic [AW-1:0] ABASE = 16'h0100;
  localparam logic [AW-1:0] BBASE = 16'h0000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_pending = 1'b0, req_erase = 1'b0, req_whole = 1'b0;
  logic [PW-1:0] req_page = '0;
  logic          done, busy, mem_valid, mem_write;
  logic          mem_ready = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata, mem_rdata;

  always #2 clk = ~clk;

  flash_op_engine #(
    .ADDR_W(AW), .DATA_W(8), .PAGE_W(PW), .PAGE_BYTES(PB), .SECTOR_PAGES(SP),
    .ARRAY_PAGES(AP), .ARRAY_BASE(ABASE), .BUF_BASE(BBASE)
  ) u_dut (
    .clk(clk), .rst(rst), .req_pending(req_pending), .req_erase(req_erase),
    .req_whole(req_whole), .req_page(req_page), .done(done), .busy(busy),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [7:0] mem [0:511];
  logic [7:0] exp_img [0:511];
  int  n_chk = 0, n_bad = 0;
  int  wr_cnt = 0, rd_cnt = 0, oob_cnt = 0, hold_bad = 0, vld_cnt = 0;
  int  win_lo = 0, win_hi = 0;
  bit  stall_en = 0;
  logic          stall_prev = 1'b0, wr_prev = 1'b0;
  logic [AW-1:0] addr_prev = '0;
  logic [7:0]    data_prev = '0;

  // Memory model: one-cycle read latency, random bytes outside the capture cycle (R10).
  always @(posedge clk) begin
    if (!rst) begin
      if (stall_prev && !(mem_valid && mem_addr == addr_prev &&
                          mem_wdata == data_prev && mem_write == wr_prev))
        hold_bad++;
      if (mem_valid) vld_cnt++;
    end
    stall_prev <= !rst && mem_valid && !mem_ready;
    addr_prev  <= mem_addr;
    data_prev  <= mem_wdata;
    wr_prev    <= mem_write;
    if (!rst && mem_valid && mem_ready) begin
      if (mem_write) begin
        mem[mem_addr[8:0]] <= mem_wdata;
        wr_cnt++;
        if (int'(mem_addr) < win_lo || int'(mem_addr) > win_hi) oob_cnt++;
        mem_rdata <= 8'($urandom);
      end else begin
        rd_cnt++;
        mem_rdata <= mem[mem_addr[8:0]];
      end
    end else begin
      mem_rdata <= 8'($urandom);
    end
  end

  always @(negedge clk) mem_ready <= stall_en ? (($urandom % 4) != 0) : 1'b1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic fill_random();
    for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
  endtask

  task automatic run_op(input logic [PW-1:0] page, input bit erase, input bit whole,
                        input bit scramble, input bit drop_early, input int hold,
                        input string tag);
    int base, span, cyc, mism, first, busy_hits;
    bit prog;
    prog = !erase;
    if (prog) begin
      base = int'(ABASE) + int'(page) * PB; span = PB;
    end else if (whole) begin
      base = int'(ABASE); span = AB;
    end else begin
      base = int'(ABASE) + (int'(page) & ~(SP - 1)) * PB; span = SP * PB;
    end
    for (int i = 0; i < 512; i++) exp_img[i] = mem[i];
    for (int k = 0; k < span; k++)
      exp_img[base + k] = prog ? (mem[int'(BBASE) + k] & mem[base + k]) : 8'hFF;
    win_lo = base; win_hi = base + span - 1;
    wr_cnt = 0; rd_cnt = 0; oob_cnt = 0;

    @(negedge clk);
    req_page = page; req_erase = erase; req_whole = whole; req_pending = 1'b1;
    @(negedge clk);
    check(busy === 1'b1, "R6", "busy one cycle after request", int'(busy), 1);

    cyc = 0;
    while (done !== 1'b1 && cyc < 20000) begin
      if (scramble && cyc == 2) begin
        req_page = ~page; req_erase = ~erase; req_whole = ~whole;  // R8
      end
      @(negedge clk);
      cyc++;
    end
    check(done === 1'b1, "R6", "done reached", int'(done), 1);

    if (drop_early) begin
      req_pending = 1'b0;
    end else begin
      @(negedge clk);
      check(done === 1'b0 && busy === 1'b0, "R6", "done single cycle then idle",
            int'(done) + int'(busy), 0);
      busy_hits = 0;
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        if (busy || mem_valid) busy_hits++;
      end
      if (hold > 0) check(busy_hits == 0, "R7", "held pending restarted engine", busy_hits, 0);
      req_pending = 1'b0;
    end

    mism = 0; first = -1;
    for (int i = 0; i < 512; i++)
      if (mem[i] !== exp_img[i]) begin
        mism++;
        if (first < 0) first = i;
      end
    check(mism == 0, tag, "memory image mismatched bytes", mism, 0);
    if (mism != 0) $display("  first mismatch at %0d: actual %0h expected %0h",
                            first, mem[first], exp_img[first]);
    check(wr_cnt == span, tag, "write count", wr_cnt, span);
    check(oob_cnt == 0, tag, "writes outside range", oob_cnt, 0);
    check(rd_cnt == (prog ? 2 * PB : 0), tag, "read count", rd_cnt, prog ? 2 * PB : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    fill_random();
    repeat (4) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && mem_valid === 1'b0, "R1", "reset state",
          int'(busy) + int'(done) + int'(mem_valid), 0);
    rst = 1'b0;

    // R2: no pending, random fields, no traffic
    vld_cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      req_page = PW'($urandom % AP); req_erase = 1'($urandom); req_whole = 1'($urandom);
    end
    check(vld_cnt == 0 && busy === 1'b0, "R2", "traffic without pending", vld_cnt, 0);

    run_op(10'd3, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R3");
    stall_en = 1;
    run_op(10'd15, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R10");
    fill_random();
    run_op(10'd6, 1'b1, 1'b0, 1'b0, 1'b0, 0, "R4");
    run_op(10'd13, 1'b1, 1'b0, 1'b0, 1'b0, 0, "R4");
    run_op(10'd1023, 1'b1, 1'b1, 1'b0, 1'b0, 0, "R5");
    fill_random();
    run_op(10'd5, 1'b0, 1'b0, 1'b0, 1'b0, 30, "R7");
    run_op(10'd2, 1'b0, 1'b0, 1'b1, 1'b0, 0, "R8");
    // done and re-arm in the same cycle, then a new request straight away
    run_op(10'd9, 1'b0, 1'b0, 1'b0, 1'b1, 0, "R3");
    run_op(10'd10, 1'b1, 1'b0, 1'b0, 1'b0, 0, "R7");

    for (int n = 0; n < 14; n++) begin
      int kind;
      fill_random();
      kind = int'($urandom % 3);
      run_op(PW'($urandom % AP), kind != 0, kind == 2, 1'($urandom), 1'b0, 0,
             kind == 0 ? "R3" : (kind == 1 ? "R4" : "R5"));
    end

    check(hold_bad == 0, "R9", "stalled request changed", hold_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule